// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast input clock by a programmable ratio. It is built from a dual-modulus prescaler, a swallow counter and a main counter. One input clock cycle stands for one cycle of the oscillator being divided. The prescaler is modelled as a digital counter. It divides by P, or by P+1 while the modulus-control signal is high.

Each output period works in three steps:
- The swallow counter holds the modulus control high for the first A prescaler cycles of the period.
- The main counter ends the period after N prescaler cycles.
- The block then issues a one-cycle comparison pulse.

The total ratio is therefore P·N + A.

The settings are a band select, the swallow count A and the main count N. The block samples them only at a period boundary, so a period is never built from a mix of old and new values. A setting with A not below N is clamped to A = N−1 and raises a sticky error flag. A power-save input freezes all counting and keeps the pulse output low.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst` is high, `fp_out`, `mod_ctrl` and `cfg_err` are all low. A reset clears a previously raised `cfg_err`.
- R2: With constant settings and A < N, `fp_out` rises every P·N + A input cycles and stays high for exactly one cycle.
- R3: `sw_sel` = 1 selects the prescaler modulus P = P_LO (32/33 by default). `sw_sel` = 0 selects P = P_HI (64/65 by default).
- R4: `mod_ctrl` is high for exactly A·(P+1) input cycles at the start of each period, beginning in the cycle in which `fp_out` is high. It is low when the main counter terminates.
- R5: After reset is released, the first `fp_out` pulse is visible after P·N + A + 1 rising edges, counting the first edge with `rst` low.
- R6: Settings are sampled only on the edge that raises `fp_out`. A change made in the middle of a period leaves that period's length unchanged, and the next period uses the new ratio.
- R7: If A ≥ N is sampled at a boundary, that period uses A = N−1. `cfg_err` rises in the same cycle as `fp_out` and stays high until reset. Legal settings never raise it.
- R8: While `pwr_save` is high, no counter advances, `fp_out` is low and `mod_ctrl` holds its value. A period that contains H held cycles lasts P·N + A + H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided input clock (oscillator side) |
| rst | input | 1 | Synchronous active-high reset |
| pwr_save | input | 1 | High freezes counting and holds fp_out low |
| sw_sel | input | 1 | Band select: 1 = P_LO modulus, 0 = P_HI modulus |
| a_set | input | A_W | Swallow count A |
| n_set | input | N_W | Main count N |
| fp_out | output | 1 | One-cycle comparison pulse at the end of each period |
| mod_ctrl | output | 1 | Prescaler modulus control (high = divide by P+1) |
| cfg_err | output | 1 | Sticky flag: A ≥ N was sampled at a boundary |

## Verification
The assertions take it as given that `n_set` is never below 5. This keeps every prescaler cycle and every period long enough that a pulse cannot follow another pulse directly, and it makes N−1 a valid clamp value. The bench therefore drives N only from 5 upward.

The bench uses a reduced configuration (P of 4 or 8, a 3-bit A and a 4-bit N). This lets it sweep every legal pair of A and N for both bands within the run. Out-of-range A is applied only in a dedicated clamp phase. Settings change only on falling edges, either at a measured pulse or a fixed number of cycles into a period.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Band select encoding on sw_sel
  typedef enum logic {
    BAND_WIDE   = 1'b0,   // larger modulus pair
    BAND_NARROW = 1'b1    // smaller modulus pair
  } band_e;

endpackage

// File: rtl/psd_setting_guard.sv
// Combinational setting conditioning: clamps the swallow count below the
// main count and picks the prescaler modulus for the selected band.
module psd_setting_guard
  import psd_pkg::*;
#(
  parameter int A_W  = 7,
  parameter int N_W  = 11,
  parameter int P_LO = 32,
  parameter int P_HI = 64,
  parameter int PC_W = 7
) (
  input  logic            sw_sel,
  input  logic [A_W-1:0]  a_in,
  input  logic [N_W-1:0]  n_in,
  output logic [A_W-1:0]  a_eff,
  output logic [N_W-1:0]  n_eff,
  output logic [PC_W-1:0] p_eff,
  output logic            viol
);
  localparam int CW = (A_W > N_W) ? A_W : N_W;

  logic [CW-1:0] a_w;
  logic [CW-1:0] n_w;
  logic [CW-1:0] n_m1;
  band_e         band;

  assign a_w   = CW'(a_in);
  assign n_w   = CW'(n_in);
  assign n_m1  = n_w - CW'(1);
  assign viol  = (a_w >= n_w);
  assign a_eff = viol ? A_W'(n_m1) : a_in;
  assign n_eff = n_in;
  assign band  = band_e'(sw_sel);
  assign p_eff = (band == BAND_NARROW) ? PC_W'(P_LO) : PC_W'(P_HI);

endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler model: one prescaler cycle lasts mod_p or mod_p+1
// input cycles; tick marks the last input cycle of a prescaler cycle.
module psd_prescaler #(
  parameter int PC_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PC_W-1:0] mod_p,
  input  logic            mc_next,
  output logic            tick
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (en) begin
      if (pc_q == '0) pc_q <= mc_next ? mod_p : (mod_p - PC_W'(1));
      else            pc_q <= pc_q - PC_W'(1);
    end
  end

  assign tick = (pc_q == '0);

endmodule

// File: rtl/psd_count_ctrl.sv
// Swallow and main counters, active-setting registers, boundary control,
// pulse output and sticky setting error.
module psd_count_ctrl #(
  parameter int A_W  = 7,
  parameter int N_W  = 11,
  parameter int PC_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic [A_W-1:0]  a_eff,
  input  logic [N_W-1:0]  n_eff,
  input  logic [PC_W-1:0] p_eff,
  input  logic            viol,
  output logic [PC_W-1:0] mod_p,
  output logic            mc_next,
  output logic            mod_ctrl,
  output logic            fp_out,
  output logic            cfg_err,
  output logic            load,
  output logic            term
);
  logic            primed_q;
  logic [A_W-1:0]  sc_q;
  logic [N_W-1:0]  mcnt_q;
  logic [PC_W-1:0] p_act_q;
  logic            mc_q;
  logic            fp_q;
  logic            err_q;

  assign term    = primed_q & tick & (mcnt_q == N_W'(1));
  assign load    = en & (~primed_q | term);
  assign mod_p   = load ? p_eff : p_act_q;
  assign mc_next = load ? (a_eff != '0) : (sc_q > A_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      sc_q     <= '0;
      mcnt_q   <= '0;
      p_act_q  <= '0;
      mc_q     <= 1'b0;
      fp_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      fp_q <= en & term;
      if (load && viol) err_q <= 1'b1;
      if (load) begin
        primed_q <= 1'b1;
        sc_q     <= a_eff;
        mcnt_q   <= n_eff;
        p_act_q  <= p_eff;
        mc_q     <= (a_eff != '0);
      end else if (en && tick && primed_q) begin
        if (sc_q != '0) sc_q <= sc_q - A_W'(1);
        mcnt_q <= mcnt_q - N_W'(1);
        mc_q   <= (sc_q > A_W'(1));
      end
    end
  end

  assign mod_ctrl = mc_q;
  assign fp_out   = fp_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int A_W  = 7,
  parameter int N_W  = 11,
  parameter int P_LO = 32,
  parameter int P_HI = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_save,
  input  logic           sw_sel,
  input  logic [A_W-1:0] a_set,
  input  logic [N_W-1:0] n_set,
  output logic           fp_out,
  output logic           mod_ctrl,
  output logic           cfg_err
);
  localparam int P_MAX = (P_HI > P_LO) ? P_HI : P_LO;
  localparam int PC_W  = $clog2(P_MAX + 1);

  logic            en_w;
  logic [A_W-1:0]  a_eff_w;
  logic [N_W-1:0]  n_eff_w;
  logic [PC_W-1:0] p_eff_w;
  logic            viol_w;
  logic [PC_W-1:0] mod_p_w;
  logic            mc_next_w;
  logic            tick_w;
  logic            load_w;
  logic            term_w;

  assign en_w = ~pwr_save;

  psd_setting_guard #(
    .A_W(A_W), .N_W(N_W), .P_LO(P_LO), .P_HI(P_HI), .PC_W(PC_W)
  ) u_guard (
    .sw_sel (sw_sel),
    .a_in   (a_set),
    .n_in   (n_set),
    .a_eff  (a_eff_w),
    .n_eff  (n_eff_w),
    .p_eff  (p_eff_w),
    .viol   (viol_w)
  );

  psd_prescaler #(
    .PC_W(PC_W)
  ) u_presc (
    .clk     (clk),
    .rst     (rst),
    .en      (en_w),
    .mod_p   (mod_p_w),
    .mc_next (mc_next_w),
    .tick    (tick_w)
  );

  psd_count_ctrl #(
    .A_W(A_W), .N_W(N_W), .PC_W(PC_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en_w),
    .tick     (tick_w),
    .a_eff    (a_eff_w),
    .n_eff    (n_eff_w),
    .p_eff    (p_eff_w),
    .viol     (viol_w),
    .mod_p    (mod_p_w),
    .mc_next  (mc_next_w),
    .mod_ctrl (mod_ctrl),
    .fp_out   (fp_out),
    .cfg_err  (cfg_err),
    .load     (load_w),
    .term     (term_w)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker (
  input logic clk,
  input logic rst,
  input logic pwr_save,
  input logic fp_out,
  input logic mod_ctrl,
  input logic cfg_err,
  input logic load_w,
  input logic term_w,
  input logic viol_w
);

  AST_FP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fp_out |=> !fp_out); // R2

  AST_FP_FOLLOWS_TERM: assert property (@(posedge clk) disable iff (rst)
    (term_w && !pwr_save) |=> fp_out); // R2

  AST_MC_LOW_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    term_w |-> !mod_ctrl); // R4

  AST_SAVE_FP_LOW: assert property (@(posedge clk) disable iff (rst)
    pwr_save |=> !fp_out); // R8

  AST_SAVE_MC_HOLD: assert property (@(posedge clk) disable iff (rst)
    pwr_save |=> $stable(mod_ctrl)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R7

  AST_ERR_ON_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (load_w && viol_w) |=> cfg_err); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!fp_out && !mod_ctrl && !cfg_err)); // R1

endmodule

bind pulse_swallow_divider psd_checker u_psd_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_save (pwr_save),
  .fp_out   (fp_out),
  .mod_ctrl (mod_ctrl),
  .cfg_err  (cfg_err),
  .load_w   (load_w),
  .term_w   (term_w),
  .viol_w   (viol_w)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  localparam int A_W  = 3;
  localparam int N_W  = 4;
  localparam int P_LO = 4;
  localparam int P_HI = 8;
  localparam int LIMIT = 2000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pwr_save = 1'b0;
  logic           sw_sel = 1'b1;
  logic [A_W-1:0] a_set = '0;
  logic [N_W-1:0] n_set = N_W'(5);
  logic           fp_out;
  logic           mod_ctrl;
  logic           cfg_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pulse_swallow_divider #(
    .A_W(A_W), .N_W(N_W), .P_LO(P_LO), .P_HI(P_HI)
  ) u_pulse_swallow_divider (
    .clk(clk), .rst(rst), .pwr_save(pwr_save), .sw_sel(sw_sel),
    .a_set(a_set), .n_set(n_set),
    .fp_out(fp_out), .mod_ctrl(mod_ctrl), .cfg_err(cfg_err)
  );

  function automatic int ratio(input int sw, input int n, input int a);
    return (sw != 0 ? P_LO : P_HI) * n + a;
  endfunction

  function automatic int pmod(input int sw);
    return (sw != 0) ? P_LO : P_HI;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int sw, input int n, input int a);
    sw_sel = sw[0];
    n_set  = N_W'(n);
    a_set  = A_W'(a);
  endtask

  // advance falling edges until fp_out is seen high; adds to cyc
  task automatic run_to_fp(inout int cyc);
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      cyc++;
      if (fp_out) break;
    end
  endtask

  // called at a falling edge where fp_out is high; measures to next pulse
  task automatic measure(output int cyc, output int mch);
    cyc = 0;
    mch = mod_ctrl ? 1 : 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      cyc++;
      if (fp_out) break;
      if (mod_ctrl) mch++;
    end
  endtask

  initial begin
    int cyc;
    int mch;
    int mc_hold;
    bit fp_seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(fp_out == 1'b0, "R1 fp_out in reset", int'(fp_out), 0);
    check(mod_ctrl == 1'b0, "R1 mod_ctrl in reset", int'(mod_ctrl), 0);
    check(cfg_err == 1'b0, "R1 cfg_err in reset", int'(cfg_err), 0);

    // R5: first pulse timing
    apply(1, 5, 2);
    rst = 1'b0;
    cyc = 0;
    run_to_fp(cyc);
    check(cyc == ratio(1, 5, 2) + 1, "R5 first pulse delay", cyc, ratio(1, 5, 2) + 1);
    measure(cyc, mch);
    check(cyc == ratio(1, 5, 2), "R2 steady period", cyc, ratio(1, 5, 2));
    check(mch == 2 * (P_LO + 1), "R4 modulus-high cycles", mch, 2 * (P_LO + 1));

    // R2 R3 R4: sweep all legal settings of both bands
    for (int sw = 0; sw < 2; sw++) begin
      for (int n = 5; n < (1 << N_W); n++) begin
        for (int a = 0; a < (1 << A_W); a++) begin
          if (a >= n) continue;
          apply(sw, n, a);
          cyc = 0;
          run_to_fp(cyc);
          measure(cyc, mch);
          check(cyc == ratio(sw, n, a), "R2 R3 sweep period", cyc, ratio(sw, n, a));
          check(mch == a * (pmod(sw) + 1), "R4 sweep modulus-high", mch, a * (pmod(sw) + 1));
        end
      end
    end
    check(cfg_err == 1'b0, "R7 no error for legal settings", int'(cfg_err), 0);

    // R6: mid-period change applies at the next boundary only
    apply(0, 6, 3);
    cyc = 0;
    run_to_fp(cyc);
    cyc = 0;
    repeat (10) begin @(negedge clk); cyc++; end
    apply(1, 9, 1);
    run_to_fp(cyc);
    check(cyc == ratio(0, 6, 3), "R6 current period keeps old ratio", cyc, ratio(0, 6, 3));
    measure(cyc, mch);
    check(cyc == ratio(1, 9, 1), "R6 next period uses new ratio", cyc, ratio(1, 9, 1));

    // R8: power save stretches the period and holds outputs
    cyc = 0;
    repeat (7) begin @(negedge clk); cyc++; end
    mc_hold = int'(mod_ctrl);
    pwr_save = 1'b1;
    fp_seen = 1'b0;
    mch = 0;
    repeat (13) begin
      @(negedge clk);
      cyc++;
      if (fp_out) fp_seen = 1'b1;
      if (int'(mod_ctrl) != mc_hold) mch++;
    end
    pwr_save = 1'b0;
    check(fp_seen == 1'b0, "R8 fp_out low while saving", int'(fp_seen), 0);
    check(mch == 0, "R8 mod_ctrl held while saving", mch, 0);
    run_to_fp(cyc);
    check(cyc == ratio(1, 9, 1) + 13, "R8 stretched period", cyc, ratio(1, 9, 1) + 13);

    // R7: clamp A >= N to N-1 and sticky error
    apply(1, 6, 7);
    cyc = 0;
    run_to_fp(cyc);
    check(cfg_err == 1'b1, "R7 error raised at boundary", int'(cfg_err), 1);
    measure(cyc, mch);
    check(cyc == ratio(1, 6, 5), "R7 clamped period", cyc, ratio(1, 6, 5));
    check(mch == 5 * (P_LO + 1), "R7 clamped modulus-high", mch, 5 * (P_LO + 1));
    apply(1, 6, 2);
    cyc = 0;
    run_to_fp(cyc);
    measure(cyc, mch);
    check(cyc == ratio(1, 6, 2), "R7 legal period after clamp", cyc, ratio(1, 6, 2));
    check(cfg_err == 1'b1, "R7 error stays set", int'(cfg_err), 1);

    // R1: reset clears the sticky error
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cfg_err == 1'b0, "R1 reset clears error", int'(cfg_err), 0);
    check(fp_out == 1'b0, "R1 fp_out low after reset", int'(fp_out), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule